// File: doc/BRIEF.md
# SD Card Clock Divider with Identification and Data Modes

This block derives the SD card clock from the core clock using a programmable divider. Software stores a divider value in an 11-bit register. The value holds the divide ratio minus two, so the card clock period is (value + 2) core cycles. Value 0 gives half the core clock. The all-ones value 0x7FF gives the slowest clock, with a ratio of 2049.

A mode input tells the block whether the card is being identified or is moving data. In identification mode the full 11-bit value sets the ratio. In data mode only the three least significant bits of the value are used, which gives ratios from 2 to 9. A slow-card input overrides this and keeps the full 11-bit value in both modes. For odd ratios the high phase is one core cycle longer than the low phase.

A change of the value, the mode or the slow-card bit is picked up only at the start of an output period. A period that is already running always completes with its old length, so the output never glitches. Beside the card clock, the block drives two one-cycle strobes for the command and data engines: one marks each rising edge and one marks each falling edge.

Top module: `sd_clk_divider`

## Requirements
- R1: With mode_data = 0, the card clock period is cfg_div + 2 core cycles, for every 11-bit value of cfg_div.
- R2: For a ratio N, the card clock is high for (N+1)/2 core cycles (rounded down) and then low for N/2 core cycles (rounded down). For odd N the high phase is therefore one cycle longer.
- R3: With mode_data = 1 and slow_card = 0, only bits [2:0] of the stored value count, giving a ratio of value[2:0] + 2. Bits [10:3] have no effect.
- R4: With slow_card = 1, the full 11-bit stored value sets the ratio whatever the state of mode_data.
- R5: The stored value resets to 507. While rst_n is low, sd_clk, rise_tick and fall_tick are 0. The first period after reset lasts 509 cycles: 255 high and 254 low.
- R6: rise_tick is 1 for exactly the first core cycle in which sd_clk is high, and fall_tick is 1 for exactly the first core cycle in which sd_clk is low. Neither strobe is set in any other cycle.
- R7: A new value, mode or slow-card setting that arrives during a period does not change that period. It takes effect from the next rising edge of sd_clk.
- R8: The stored value 0x7FF gives a ratio of 2049, with 1025 cycles high and 1024 cycles low.
- R9: cfg_div is stored only in a cycle where cfg_we is 1. In every other cycle cfg_div has no effect on the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the divider value |
| cfg_div | input | 11 | New divider value (ratio minus two) |
| slow_card | input | 1 | 1: use the full 11-bit value in every mode |
| mode_data | input | 1 | 0: identification mode, 1: data mode |
| sd_clk | output | 1 | Card clock (registered) |
| rise_tick | output | 1 | One-cycle strobe in the first high cycle of sd_clk |
| fall_tick | output | 1 | One-cycle strobe in the first low cycle of sd_clk |

## Verification
The hardest case to reach from the ports is a setting that changes while a period is running. It must leave that period whole and apply only to the following one. To create it, the bench drives the new value or mode in the very cycle it sees a rising-edge strobe. It then measures two back-to-back periods with no gap and expects the old length followed by the new one. The same alignment is used with the write strobe held low, to show that an unlatched value changes nothing. Sweeps over the divider value in each mode cover the odd/even split of each period and the position of each strobe.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;
  typedef enum logic {
    CLK_MODE_IDENT = 1'b0,
    CLK_MODE_DATA  = 1'b1
  } clk_mode_e;
endpackage

// File: rtl/sdclk_div_reg.sv
module sdclk_div_reg #(
  parameter int DIV_W     = 11,
  parameter int RESET_DIV = 507
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [DIV_W-1:0] wdata,
  output logic [DIV_W-1:0] div_q
);
  localparam logic [DIV_W-1:0] RST_VAL = DIV_W'(RESET_DIV);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  div_q <= RST_VAL;
    else if (we) div_q <= wdata;
  end

  assert_hold_without_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(div_q));
endmodule

// File: rtl/sdclk_ratio_sel.sv
module sdclk_ratio_sel
  import sdclk_pkg::*;
#(
  parameter int DIV_W   = 11,
  parameter int DATA_W  = 3,
  parameter int RATIO_W = DIV_W + 1
) (
  input  logic [DIV_W-1:0]   div_q,
  input  logic               slow_card,
  input  clk_mode_e          mode,
  output logic [RATIO_W-1:0] ratio
);
  logic [DIV_W-1:0] data_val;
  logic [DIV_W-1:0] chosen;

  generate
    if (DATA_W >= DIV_W) begin : g_full
      assign data_val = div_q;
    end else begin : g_trim
      assign data_val = {{(DIV_W-DATA_W){1'b0}}, div_q[DATA_W-1:0]};
    end
  endgenerate

  always_comb begin
    if (mode == CLK_MODE_DATA && !slow_card) chosen = data_val;
    else                                     chosen = div_q;
    ratio = RATIO_W'(chosen) + RATIO_W'(2);
  end
endmodule

// File: rtl/sdclk_phase_gen.sv
module sdclk_phase_gen #(
  parameter int RATIO_W     = 12,
  parameter int RESET_RATIO = 509
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [RATIO_W-1:0] ratio_in,
  output logic               sd_clk,
  output logic               rise_tick,
  output logic               fall_tick
);
  localparam logic [RATIO_W-1:0] RST_RATIO = RATIO_W'(RESET_RATIO);
  localparam logic [RATIO_W-1:0] RST_CNT   = RATIO_W'(RESET_RATIO - 1);

  logic [RATIO_W-1:0] ratio_q, cnt_q, cnt_nx, high_len;
  logic [RATIO_W:0]   ratio_p1;
  logic               wrap;

  always_comb begin
    ratio_p1 = {1'b0, ratio_q} + {{RATIO_W{1'b0}}, 1'b1};
    high_len = ratio_p1[RATIO_W:1];
    wrap     = (cnt_q == ratio_q - RATIO_W'(1));
    cnt_nx   = cnt_q + RATIO_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ratio_q   <= RST_RATIO;
      cnt_q     <= RST_CNT;
      sd_clk    <= 1'b0;
      rise_tick <= 1'b0;
      fall_tick <= 1'b0;
    end else if (wrap) begin
      ratio_q   <= ratio_in;
      cnt_q     <= '0;
      sd_clk    <= 1'b1;
      rise_tick <= 1'b1;
      fall_tick <= 1'b0;
    end else begin
      cnt_q     <= cnt_nx;
      sd_clk    <= (cnt_nx < high_len);
      rise_tick <= 1'b0;
      fall_tick <= (cnt_nx == high_len);
    end
  end

  assert_ticks_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_tick && fall_tick));
  assert_rise_at_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sd_clk) |-> rise_tick);
  assert_fall_at_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sd_clk) |-> fall_tick);
  assert_rise_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rise_tick |-> sd_clk);
  assert_ratio_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(ratio_q));
  assert_count_in_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < ratio_q);
endmodule

// File: rtl/sd_clk_divider.sv
module sd_clk_divider
  import sdclk_pkg::*;
#(
  parameter int DIV_W     = 11,
  parameter int DATA_W    = 3,
  parameter int RESET_DIV = 507
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             slow_card,
  input  logic             mode_data,
  output logic             sd_clk,
  output logic             rise_tick,
  output logic             fall_tick
);
  localparam int RATIO_W = DIV_W + 1;

  logic [DIV_W-1:0]   div_q;
  logic [RATIO_W-1:0] ratio;
  clk_mode_e          mode;

  assign mode = clk_mode_e'(mode_data);

  sdclk_div_reg #(.DIV_W(DIV_W), .RESET_DIV(RESET_DIV)) u_reg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_div), .div_q(div_q)
  );

  sdclk_ratio_sel #(.DIV_W(DIV_W), .DATA_W(DATA_W), .RATIO_W(RATIO_W)) u_sel (
    .div_q(div_q), .slow_card(slow_card), .mode(mode), .ratio(ratio)
  );

  sdclk_phase_gen #(.RATIO_W(RATIO_W), .RESET_RATIO(RESET_DIV + 2)) u_gen (
    .clk(clk), .rst_n(rst_n), .ratio_in(ratio),
    .sd_clk(sd_clk), .rise_tick(rise_tick), .fall_tick(fall_tick)
  );
endmodule

// File: tb/test_sd_clk_divider.sv
`timescale 1ns/1ps
module test_sd_clk_divider;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [10:0] cfg_div = '0;
  logic        slow_card = 1'b0;
  logic        mode_data = 1'b0;
  logic        sd_clk, rise_tick, fall_tick;

  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  sd_clk_divider i_sd_clk_divider (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_div(cfg_div),
    .slow_card(slow_card), .mode_data(mode_data),
    .sd_clk(sd_clk), .rise_tick(rise_tick), .fall_tick(fall_tick)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic program_div(input int v);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_div = 11'(v);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Measures one period; ends on the negedge where the next rise_tick shows.
  task automatic measure(input bit aligned, output int h, output int l, output bit tick_ok);
    if (!aligned) begin
      do @(negedge clk); while (!rise_tick);
    end
    tick_ok = sd_clk && !fall_tick;
    h = 1;
    l = 0;
    forever begin
      @(negedge clk);
      if (!sd_clk) break;
      if (rise_tick || fall_tick) tick_ok = 1'b0;
      h++;
    end
    tick_ok = tick_ok && fall_tick && !rise_tick;
    l = 1;
    forever begin
      @(negedge clk);
      if (rise_tick) break;
      if (sd_clk || fall_tick) tick_ok = 1'b0;
      l++;
    end
  endtask

  task automatic expect_period(input string tag, input int n, input bit aligned);
    int h, l;
    bit t;
    measure(aligned, h, l, t);
    check(h == (n + 1) / 2, {tag, " high"}, h, (n + 1) / 2);
    check(l == n / 2, {tag, " low"}, l, n / 2);
    check(t, {tag, " R6 strobes"}, int'(t), 1);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    int h, l;
    bit t;
    // R5: reset state
    repeat (3) @(negedge clk);
    check(!sd_clk && !rise_tick && !fall_tick, "R5 reset outputs", int'(sd_clk), 0);
    rst_n = 1'b1;
    expect_period("R5 first period 509", 509, 0);

    // R1/R2: identification sweep
    for (int v = 0; v < 40; v++) begin
      program_div(v);
      expect_period($sformatf("R1 R2 ident v=%0d", v), v + 2, 0);
    end

    // R8: maximum value
    program_div(11'h7FF);
    expect_period("R8 max value", 2049, 0);

    // R3: data mode uses low three bits only
    mode_data = 1'b1;
    for (int k = 0; k < 8; k++) begin
      program_div((((k * 37) % 255 + 1) << 3) | k);
      expect_period($sformatf("R3 data k=%0d", k), k + 2, 0);
    end

    // R4: slow card forces full value
    slow_card = 1'b1;
    for (int k = 0; k < 8; k++) begin
      program_div((3 << 3) | k);
      expect_period($sformatf("R4 slow data k=%0d", k), 24 + k + 2, 0);
    end
    mode_data = 1'b0;
    program_div(13);
    expect_period("R4 slow ident", 15, 0);
    slow_card = 1'b0;

    // R7: value change within a running period
    program_div(5);
    measure(0, h, l, t);
    fork
      expect_period("R7 old value kept", 7, 1);
      begin cfg_we = 1'b1; cfg_div = 11'd1; @(negedge clk); cfg_we = 1'b0; end
    join
    expect_period("R7 new value next", 3, 1);

    // R7: mode change within a running period
    program_div(13);
    measure(0, h, l, t);
    fork
      expect_period("R7 old mode kept", 15, 1);
      begin mode_data = 1'b1; end
    join
    expect_period("R7 data mode next", 7, 1);
    mode_data = 1'b0;

    // R9: cfg_div without write strobe has no effect
    program_div(9);
    measure(0, h, l, t);
    fork
      expect_period("R9 no write current", 11, 1);
      begin cfg_div = 11'd0; @(negedge clk); cfg_div = 11'd300; end
    join
    expect_period("R9 no write next", 11, 1);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule